// File: doc/BRIEF.md
# ADC Serial Command Interface Slave

This block is the device-side digital front end of a successive-approximation converter's serial port. It runs on a fast system clock and samples the chip select, serial clock and data input pins through synchronizers. While chip select is low it ignores leading zeros on the data line. The first 1 it sees opens a command byte, and it collects the seven command bits that follow. From those bits it decodes an input-mux channel, a single-ended/differential flag, an output coding and a power/clock mode.

In external-clock mode the conversion is paced by serial clock edges. In internal-clock mode a cycle counter times an acquisition phase and then a conversion phase. At the end of conversion the block latches a 10-bit value from a parallel port that stands in for the SAR core, and raises an end-of-conversion strobe. It then shifts the value out MSB first, followed by zeros. In internal-clock mode a new command byte may arrive while the previous result is still leaving the chip.

A rising chip select aborts any frame. It releases the data output and re-arms the start-bit search.

Top module: `adc_if_slave`

## Requirements
- R1: After chip select falls, zeros sampled on rising serial clock edges are ignored. The first 1 is the start bit, and the next seven rising-edge samples form the command byte.
- R2: The command bits arrive in this order: channel bit 2, channel bit 1, channel bit 0, unipolar flag, single-ended flag, mode bit 1, mode bit 0. `mux_sel`, `mux_single` and `pwr_mode` take the channel, single-ended flag and mode bits, and change only when all seven bits have been received.
- R3: Mode 2'b11 (external clock): the parallel value is latched on the second rising serial edge after the last command bit, and `sstrb` rises. Bit B9 appears on the falling edge that follows.
- R4: Mode 2'b10 (internal clock): `sstrb` stays low for ACQ_CYCLES+CONV_CYCLES system clocks after the last command bit. It then rises with the latched value and falls at the next falling serial edge. That same edge shifts out B9.
- R5: Modes 2'b00 (full power-down) and 2'b01 (fast power-down) are reported on `pwr_mode`. In either mode no conversion starts, `sstrb` stays low and `dout` stays 0.
- R6: A result leaves on ten successive falling serial edges, B9 first and B0 last. Every later falling edge drives 0 until the next result is loaded.
- R7: With the unipolar flag at 1 the output word equals `conv_data`. With it at 0 the output word is `conv_data` with its MSB inverted (two's complement of an offset-binary input).
- R8: In internal-clock mode a command byte received while a result is being shifted out is accepted and starts the next acquisition. The remaining bits of the old result keep shifting out on their falling edges.
- R9: Chip select high drives `dout_en` low, clears `sstrb` and `dout`, discards a partial command byte or a running conversion, and leaves the decoded outputs unchanged. The next frame searches for a fresh start bit.
- R10: After reset, `dout_en`, `dout`, `sstrb`, `mux_sel`, `mux_single` and `pwr_mode` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low (asynchronous pin) |
| sclk | input | 1 | Serial clock pin |
| din | input | 1 | Serial command data, sampled on rising serial edges |
| conv_data | input | DATA_W | Conversion value from the SAR stand-in, offset binary |
| dout | output | 1 | Serial result data, changes on falling serial edges |
| dout_en | output | 1 | Output driver enable; low means the pin floats |
| sstrb | output | 1 | End-of-conversion strobe |
| mux_sel | output | 3 | Decoded input-mux channel |
| mux_single | output | 1 | 1 = single-ended, 0 = differential |
| pwr_mode | output | 2 | Decoded power/clock mode bits |

## Verification
Two functions can fall in the same cycle here. One is the start-bit and command capture, which works on rising serial edges. The other is the shift-out of a previous internal-clock result, which works on the falling edges of the same serial cycles. The bench provokes the overlap by sending a complete command byte during the first eight output bits of an internal-clock result. It then clocks out the last two bits and waits for the second strobe. A scoreboard compares both result words bit for bit, and the bench checks that the new channel took effect and that the strobe stayed low until the new conversion finished.

// File: rtl/adc_if_pkg.sv
package adc_if_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INT_ACQ,
    ST_INT_CONV,
    ST_EXT_CONV,
    ST_OUT_INT,
    ST_OUT_EXT
  } seq_state_e;

  // field order equals arrival order after the start bit
  typedef struct packed {
    logic [2:0] chan;
    logic       unipolar;
    logic       single;
    logic [1:0] pd;
  } ctrl_word_t;

  localparam int CTRL_BITS = 7;

  localparam logic [1:0] PD_FULL = 2'b00;
  localparam logic [1:0] PD_FAST = 2'b01;
  localparam logic [1:0] PD_INT  = 2'b10;
  localparam logic [1:0] PD_EXT  = 2'b11;

endpackage

// File: rtl/adc_if_sync.sv
module adc_if_sync #(
  parameter int             W       = 3,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);

  localparam int CHAIN_W = W * STAGES;

  logic [CHAIN_W-1:0] chain_q;
  logic [CHAIN_W-1:0] chain_d;

  generate
    if (STAGES > 1) begin : g_multi
      assign chain_d = {chain_q[CHAIN_W-W-1:0], d_in};
    end else begin : g_single
      assign chain_d = d_in;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{RST_VAL}};
    end else begin
      chain_q <= chain_d;
    end
  end

  assign d_out = chain_q[CHAIN_W-1 -: W];

endmodule

// File: rtl/adc_if_ctrl_rx.sv
module adc_if_ctrl_rx #(
  parameter int NBITS = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             listen,
  input  logic             rise,
  input  logic             din,
  output logic             done,
  output logic [NBITS-1:0] word
);

  localparam int CW = $clog2(NBITS);

  logic             busy_q, busy_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [NBITS-1:0] sr_q, sr_d;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    sr_d   = sr_q;
    done   = 1'b0;
    if (clr) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (rise) begin
      if (!busy_q) begin
        if (listen && din) begin
          busy_d = 1'b1;
          cnt_d  = '0;
        end
      end else begin
        sr_d = {sr_q[NBITS-2:0], din};
        if (cnt_q == CW'(NBITS - 1)) begin
          done   = 1'b1;
          busy_d = 1'b0;
          cnt_d  = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      sr_q   <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      sr_q   <= sr_d;
    end
  end

  assign word = sr_d;

  // R1: capture opens only on a sampled 1 while the search is armed
  p_start_on_one_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(din) && $past(listen) && $past(rise));

  // R1: bit counter never runs past the command length
  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> cnt_q <= CW'(NBITS - 1));

endmodule

// File: rtl/adc_if_shift.sv
module adc_if_shift #(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          load,
  input  logic          fall,
  input  logic          bipolar,
  input  logic [DW-1:0] sample,
  output logic          dout
);

  localparam int FW = $clog2(DW + 1);

  logic [DW-1:0] sr_q, sr_d;
  logic          out_q, out_d;
  logic [DW-1:0] coded;

  // offset binary to two's complement: invert the sign bit
  assign coded = bipolar ? {~sample[DW-1], sample[DW-2:0]} : sample;

  always_comb begin
    sr_d  = sr_q;
    out_d = out_q;
    if (clr) begin
      sr_d  = '0;
      out_d = 1'b0;
    end else begin
      if (fall) begin
        out_d = sr_q[DW-1];
        sr_d  = {sr_q[DW-2:0], 1'b0};
      end
      if (load) begin
        sr_d = coded;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      out_q <= 1'b0;
    end else begin
      sr_q  <= sr_d;
      out_q <= out_d;
    end
  end

  assign dout = out_q;

  // checker-only count of bits shifted since the last load
  logic [FW-1:0] fill_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= FW'(DW);
    end else if (clr) begin
      fill_q <= FW'(DW);
    end else if (load) begin
      fill_q <= '0;
    end else if (fall && fill_q < FW'(DW)) begin
      fill_q <= fill_q + 1'b1;
    end
  end

  // R6: once all result bits are gone only zeros leave
  p_zero_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_q == FW'(DW)) && fall && !load |=> !dout);

  // R9: abort clears the output bit
  p_clear_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !dout);

endmodule

// File: rtl/adc_if_slave.sv
module adc_if_slave
  import adc_if_pkg::*;
#(
  parameter int DATA_W         = 10,
  parameter int ACQ_CYCLES     = 8,
  parameter int CONV_CYCLES    = 64,
  parameter int EXT_CONV_RISES = 2,
  parameter int SYNC_STAGES    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              din,
  input  logic [DATA_W-1:0] conv_data,
  output logic              dout,
  output logic              dout_en,
  output logic              sstrb,
  output logic [2:0]        mux_sel,
  output logic              mux_single,
  output logic [1:0]        pwr_mode
);

  localparam int MAX_A  = (ACQ_CYCLES > CONV_CYCLES) ? ACQ_CYCLES : CONV_CYCLES;
  localparam int MAX_T  = (MAX_A > EXT_CONV_RISES) ? MAX_A : EXT_CONV_RISES;
  localparam int TMR_W  = $clog2(MAX_T + 1);

  logic cs_s, sclk_s, din_s, sclk_q;
  logic rise, fall, abort;

  adc_if_sync #(
    .W       (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b100)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  ({cs_n, sclk, din}),
    .d_out ({cs_s, sclk_s, din_s})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk_s;
  end

  assign abort = cs_s;
  assign rise  = !cs_s && sclk_s && !sclk_q;
  assign fall  = !cs_s && !sclk_s && sclk_q;

  seq_state_e st_q, st_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic        listen, rx_done, load;
  logic [CTRL_BITS-1:0] rx_word;
  ctrl_word_t  cfg_q, new_cfg;
  logic        sstrb_q, sstrb_d;

  assign listen  = (st_q == ST_IDLE) || (st_q == ST_OUT_INT);
  assign new_cfg = ctrl_word_t'(rx_word);

  adc_if_ctrl_rx #(
    .NBITS (CTRL_BITS)
  ) u_rx (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (abort),
    .listen (listen),
    .rise   (rise),
    .din    (din_s),
    .done   (rx_done),
    .word   (rx_word)
  );

  // sequencer next state
  always_comb begin
    st_d  = st_q;
    tmr_d = tmr_q;
    load  = 1'b0;
    unique case (st_q)
      ST_IDLE, ST_OUT_INT: begin
        if (rx_done) begin
          tmr_d = '0;
          unique case (new_cfg.pd)
            PD_INT:  st_d = ST_INT_ACQ;
            PD_EXT:  st_d = ST_EXT_CONV;
            default: st_d = ST_IDLE;
          endcase
        end
      end
      ST_INT_ACQ: begin
        if (tmr_q == TMR_W'(ACQ_CYCLES - 1)) begin
          st_d  = ST_INT_CONV;
          tmr_d = '0;
        end else begin
          tmr_d = tmr_q + 1'b1;
        end
      end
      ST_INT_CONV: begin
        if (tmr_q == TMR_W'(CONV_CYCLES - 1)) begin
          load  = 1'b1;
          st_d  = ST_OUT_INT;
          tmr_d = '0;
        end else begin
          tmr_d = tmr_q + 1'b1;
        end
      end
      ST_EXT_CONV: begin
        if (rise) begin
          if (tmr_q == TMR_W'(EXT_CONV_RISES - 1)) begin
            load  = 1'b1;
            st_d  = ST_OUT_EXT;
            tmr_d = '0;
          end else begin
            tmr_d = tmr_q + 1'b1;
          end
        end
      end
      ST_OUT_EXT: st_d = ST_OUT_EXT;
      default:    st_d = ST_IDLE;
    endcase
    if (abort) begin
      st_d  = ST_IDLE;
      tmr_d = '0;
      load  = 1'b0;
    end
  end

  always_comb begin
    sstrb_d = sstrb_q;
    if (abort)     sstrb_d = 1'b0;
    else if (load) sstrb_d = 1'b1;
    else if (fall) sstrb_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      tmr_q   <= '0;
      sstrb_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      tmr_q   <= tmr_d;
      sstrb_q <= sstrb_d;
    end
  end

  // decoded command, enabled only by a complete byte
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (rx_done) begin
      cfg_q <= new_cfg;
    end
  end

  adc_if_shift #(
    .DW (DATA_W)
  ) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (abort),
    .load    (load),
    .fall    (fall),
    .bipolar (!cfg_q.unipolar),
    .sample  (conv_data),
    .dout    (dout)
  );

  assign dout_en    = !cs_s;
  assign sstrb      = sstrb_q;
  assign mux_sel    = cfg_q.chan;
  assign mux_single = cfg_q.single;
  assign pwr_mode   = cfg_q.pd;

  // R5: a strobe only ever follows a converting mode
  p_no_conv_pd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sstrb_q) |-> cfg_q.pd[1]);

  // R2: decoded outputs hold unless a full byte arrived
  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_done |=> $stable(cfg_q));

  // R4: strobe stays low while the internal timer runs
  p_int_busy_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_INT_ACQ || st_q == ST_INT_CONV) |-> !sstrb_q);

  // R3: in external mode the strobe follows a serial rising edge
  p_ext_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sstrb_q) && (cfg_q.pd == PD_EXT) |-> $past(rise));

  // R9: chip select high returns the sequencer to idle, strobe low
  p_abort_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (st_q == ST_IDLE) && !sstrb_q);

endmodule

// File: tb/adc_if_slave_tb.sv
module adc_if_slave_tb;

  localparam int DW    = 10;
  localparam int HALF  = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cs_n;
  logic          sclk;
  logic          din;
  logic [DW-1:0] conv_data;
  logic          dout, dout_en, sstrb, mux_single;
  logic [2:0]    mux_sel;
  logic [1:0]    pwr_mode;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  int exp_q[$];

  always #4 clk = ~clk;

  adc_if_slave u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .sclk       (sclk),
    .din        (din),
    .conv_data  (conv_data),
    .dout       (dout),
    .dout_en    (dout_en),
    .sstrb      (sstrb),
    .mux_sel    (mux_sel),
    .mux_single (mux_single),
    .pwr_mode   (pwr_mode)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int fmt(input int d, input bit uni);
    return uni ? d : (d ^ (1 << (DW - 1)));
  endfunction

  function automatic logic [7:0] cmd(input logic [2:0] ch, input logic uni,
                                     input logic sgl, input logic [1:0] pd);
    return {1'b1, ch, uni, sgl, pd};
  endfunction

  // one serial cycle: fall, drive din, sample dout, rise
  task automatic sck(input logic b, output logic q);
    @(negedge clk);
    sclk = 1'b0;
    din  = b;
    repeat (HALF) @(negedge clk);
    q    = dout;
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] c, input int lead);
    logic q;
    for (int i = 0; i < lead; i++) sck(1'b0, q);
    for (int i = 7; i >= 0; i--) sck(c[i], q);
  endtask

  task automatic zero_cycles(input int n, input string req);
    logic q;
    for (int i = 0; i < n; i++) begin
      sck(1'b0, q);
      chk(req, q, 0);
    end
  endtask

  task automatic cs_low();
    @(negedge clk);
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_high();
    @(negedge clk);
    sclk = 1'b0;
    din  = 1'b0;
    cs_n = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic wait_strobe(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (sstrb) begin
        ok = 1'b1;
        break;
      end
    end
  endtask

  // external-clock frame of 24 serial cycles
  task automatic run_ext(input logic [2:0] ch, input logic uni, input logic sgl,
                         input logic [DW-1:0] d);
    logic q;
    conv_data = d;
    exp_q.push_back(fmt(int'(d), uni));
    cs_low();
    chk("R9 dout_en while selected", dout_en, 1);
    send_byte(cmd(ch, uni, sgl, 2'b11), 0);
    chk("R2 mux_sel", mux_sel, ch);
    chk("R2 mux_single", mux_single, sgl);
    chk("R3 pwr_mode ext", pwr_mode, 3);
    sck(1'b0, q);
    chk("R3 dout before result", q, 0);
    chk("R3 sstrb low after first rise", sstrb, 0);
    sck(1'b0, q);
    chk("R3 dout before result", q, 0);
    chk("R3 sstrb high after second rise", sstrb, 1);
    for (int i = 0; i < DW; i++) sck(1'b0, q);
    zero_cycles(4, "R6 zero fill");
    cs_high();
    chk("R9 dout_en released", dout_en, 0);
  endtask

  // scoreboard monitor: one word per strobe
  initial begin
    logic [DW-1:0] w;
    int e;
    forever begin
      @(posedge sstrb);
      w = '0;
      for (int i = 0; i < DW; i++) begin
        @(posedge sclk);
        w = {w[DW-2:0], dout};
      end
      if (exp_q.size() == 0) begin
        chk("R6 R7 unexpected result word", int'(w), -1);
      end else begin
        e = exp_q.pop_front();
        chk("R6 R7 result word", int'(w), e);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    bit ok;
    logic q;
    rst_n     = 1'b0;
    cs_n      = 1'b1;
    sclk      = 1'b0;
    din       = 1'b0;
    conv_data = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    chk("R10 dout_en", dout_en, 0);
    chk("R10 dout", dout, 0);
    chk("R10 sstrb", sstrb, 0);
    chk("R10 mux_sel", mux_sel, 0);
    chk("R10 mux_single", mux_single, 0);
    chk("R10 pwr_mode", pwr_mode, 0);

    // external clock, unipolar
    run_ext(3'd5, 1'b1, 1'b1, 10'h2D3);

    // internal clock, bipolar
    conv_data = 10'h05A;
    exp_q.push_back(fmt(10'h05A, 1'b0));
    cs_low();
    send_byte(cmd(3'd2, 1'b0, 1'b0, 2'b10), 0);
    chk("R4 sstrb low at conversion start", sstrb, 0);
    chk("R2 mux_sel", mux_sel, 2);
    chk("R2 mux_single differential", mux_single, 0);
    chk("R4 pwr_mode int", pwr_mode, 2);
    repeat (60) @(negedge clk);
    chk("R4 sstrb low during timer", sstrb, 0);
    wait_strobe(ok);
    chk("R4 strobe after timer", ok, 1);
    sck(1'b0, q);
    chk("R4 strobe cleared by first fall", sstrb, 0);
    for (int i = 1; i < DW; i++) sck(1'b0, q);
    zero_cycles(2, "R6 zero fill int");
    cs_high();

    // leading zeros before the start bit
    conv_data = 10'h3FF;
    exp_q.push_back(fmt(10'h3FF, 1'b1));
    cs_low();
    send_byte(cmd(3'd7, 1'b1, 1'b0, 2'b10), 5);
    chk("R1 leading zeros skipped mux_sel", mux_sel, 7);
    chk("R1 leading zeros skipped pwr_mode", pwr_mode, 2);
    wait_strobe(ok);
    chk("R1 conversion started", ok, 1);
    for (int i = 0; i < DW; i++) sck(1'b0, q);
    cs_high();

    // R8 interleaved command during shift-out
    conv_data = 10'h155;
    exp_q.push_back(fmt(10'h155, 1'b1));
    cs_low();
    send_byte(cmd(3'd1, 1'b1, 1'b1, 2'b10), 0);
    wait_strobe(ok);
    chk("R8 first strobe", ok, 1);
    conv_data = 10'h0C3;
    exp_q.push_back(fmt(10'h0C3, 1'b0));
    send_byte(cmd(3'd6, 1'b0, 1'b1, 2'b10), 0);
    chk("R8 new channel accepted", mux_sel, 6);
    sck(1'b0, q);
    sck(1'b0, q);
    chk("R8 sstrb low during new conversion", sstrb, 0);
    wait_strobe(ok);
    chk("R8 second strobe", ok, 1);
    for (int i = 0; i < DW; i++) sck(1'b0, q);
    cs_high();

    // R5 power-down modes within one frame
    cs_low();
    send_byte(cmd(3'd3, 1'b1, 1'b1, 2'b00), 0);
    chk("R5 full power-down reported", pwr_mode, 0);
    chk("R5 mux updated", mux_sel, 3);
    repeat (100) @(negedge clk);
    chk("R5 no strobe in full power-down", sstrb, 0);
    zero_cycles(4, "R5 dout quiet");
    send_byte(cmd(3'd4, 1'b1, 1'b1, 2'b01), 0);
    chk("R5 fast power-down reported", pwr_mode, 1);
    repeat (100) @(negedge clk);
    chk("R5 no strobe in fast power-down", sstrb, 0);
    cs_high();

    // R9 abort during a partial byte
    cs_low();
    sck(1'b1, q);
    sck(1'b0, q);
    sck(1'b0, q);
    sck(1'b0, q);
    cs_high();
    chk("R9 dout_en low", dout_en, 0);
    chk("R9 partial byte discarded", mux_sel, 4);
    chk("R9 mode kept", pwr_mode, 1);

    // R9 abort during an internal conversion
    cs_low();
    send_byte(cmd(3'd0, 1'b1, 1'b1, 2'b10), 0);
    repeat (20) @(negedge clk);
    cs_high();
    repeat (100) @(negedge clk);
    chk("R9 aborted conversion gives no strobe", sstrb, 0);
    chk("R9 dout cleared", dout, 0);

    // R9 re-armed: next frame works
    run_ext(3'd0, 1'b0, 1'b1, 10'h001);

    repeat (50) @(negedge clk);
    chk("R6 all results observed", exp_q.size(), 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule